// File: doc/BRIEF.md
# PLL Configuration Word Calculator

This block turns a requested per-lane serial bit rate (kbps) and a reference clock frequency (kHz) into a 16-bit PLL setting. The setting packs a pre-divider, a feedback multiplier and a two-bit frequency-band code. Alongside the word it reports the output frequency that the word decodes to. The block avoids wide combinational dividers. A short compare-and-step loop picks the pre-divider. One shared restoring divider, producing one quotient bit per cycle, then performs the three divisions in sequence.

A request enters through a valid/ready pair. `req_ready` is high only when the block is idle and holds no unread result, so a caller may keep `req_valid` asserted for as long as it likes. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The result leaves through a second valid/ready pair. Once `res_valid` rises, the word, frequency and error flag stay frozen until the consumer raises `res_ready`. This back-pressure also blocks the next request. A reference of zero completes at once with the error flag set.

Top module: `pll_word_calc`

## Requirements
- R1: The pre-divider starts at 1. It is incremented while floor(reference / (pre-divider + 1)) is still at least 5000 kHz.
- R2: The pre-divider never exceeds 31. A reference high enough to pass the test beyond 31 yields exactly 31.
- R3: The multiplier is the rounded-up quotient ceil(rate × pre-divider / reference), computed at full precision.
- R4: The band code is computed from the full-precision output rate reference × multiplier / pre-divider (floor). It is 3 when that rate is ≥ 501000, 2 when ≥ 251000, 1 when ≥ 126000, and 0 otherwise.
- R5: `cfg_word` carries the band code in bits 15:14, zero in bit 13, the pre-divider in bits 12:8 and the low eight bits of the multiplier in bits 7:0.
- R6: `out_kbps` is floor(reference × m / pre-divider), where m is the multiplier field of the word. A zero field counts as 1.
- R7: A reference of zero gives `err` = 1, `cfg_word` = 0 and `out_kbps` = 0. A valid result sets `err` to 0.
- R8: `req_ready` is high only in the idle state with no result pending, so it is never high together with `res_valid`. After an accepted request it drops on the next cycle.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid`, `cfg_word`, `out_kbps` and `err` hold their values. One cycle after `res_ready` is high with `res_valid`, `res_valid` is low.
- R10: After reset, `req_ready` = 1, `res_valid` = 0 and `err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| rate_kbps | input | RATE_W (24) | Desired per-lane bit rate, kbps |
| ref_khz | input | REF_W (24) | Reference frequency, kHz |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| cfg_word | output | 16 | Packed PLL setting |
| out_kbps | output | REF_W+8 (32) | Frequency decoded from the word, kbps |
| err | output | 1 | Reference was zero |

## Verification
The bench drives a reference below 10000 kHz, which must keep the pre-divider at 1. It also drives one high enough to hit the clamp: without the clamp, the pre-divider field would wrap or spill into the band bits. Rates are placed on and just under each band threshold, which exposes an off-by-one comparison as a wrong code. A zero rate makes the multiplier field zero, so a design that skips the substitute-1 rule reports zero frequency. A multiplier above 255 shows whether the band comes from the full rate or from the truncated field. A long stall on `res_ready`, with the next request already waiting, catches a result that changes or a request that slips in before the pending result is read.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  localparam int unsigned FLOOR_KHZ = 5000;
  localparam int unsigned DIV_W     = 5;
  localparam int unsigned DIV_MAX   = 31;
  localparam int unsigned MFLD_W    = 8;
  localparam longint unsigned BAND3_MIN = 501000;
  localparam longint unsigned BAND2_MIN = 251000;
  localparam longint unsigned BAND1_MIN = 126000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_MUL,
    ST_OUT,
    ST_DEC,
    ST_HOLD
  } calc_state_e;
endpackage

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_calc_pkg::*;
#(
  parameter int unsigned REF_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [REF_W-1:0] ref_khz,
  output logic             done,
  output logic [DIV_W-1:0] div
);
  localparam int unsigned TW = REF_W + 2;

  logic          run;
  logic [TW-1:0] thr;
  logic          pass;

  // floor(ref/(d+1)) >= FLOOR  <=>  ref >= FLOOR*(d+1)
  assign pass = (TW'(ref_khz) >= thr) && (div < DIV_W'(DIV_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
      div  <= DIV_W'(1);
      thr  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        run <= 1'b1;
        div <= DIV_W'(1);
        thr <= TW'(2 * FLOOR_KHZ);
      end else if (run) begin
        if (pass) begin
          div <= div + DIV_W'(1);
          thr <= thr + TW'(FLOOR_KHZ);
        end else begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int unsigned NW = 54,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int unsigned CW = $clog2(NW + 1);

  logic [DW-1:0] rem_q;
  logic [CW-1:0] cnt;
  logic          run;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          fits;

  assign trial = {rem_q, quot[NW-1]};
  assign diff  = trial - {1'b0, den};
  assign fits  = trial >= {1'b0, den};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quot  <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        quot  <= num;
        rem_q <= '0;
        cnt   <= CW'(NW);
        run   <= 1'b1;
      end else if (run) begin
        rem_q <= fits ? diff[DW-1:0] : trial[DW-1:0];
        quot  <= {quot[NW-2:0], fits};
        cnt   <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_band_enc.sv
module pll_band_enc
  import pll_calc_pkg::*;
#(
  parameter int unsigned W = 54
) (
  input  logic [W-1:0] rate,
  output logic [1:0]   band
);
  always_comb begin
    if (rate >= W'(BAND3_MIN))      band = 2'd3;
    else if (rate >= W'(BAND2_MIN)) band = 2'd2;
    else if (rate >= W'(BAND1_MIN)) band = 2'd1;
    else                            band = 2'd0;
  end
endmodule

// File: rtl/pll_word_calc.sv
module pll_word_calc
  import pll_calc_pkg::*;
#(
  parameter int unsigned RATE_W = 24,
  parameter int unsigned REF_W  = 24,
  localparam int unsigned MUL_W = ((RATE_W > REF_W) ? RATE_W : REF_W) + 6,
  localparam int unsigned NUM_W = REF_W + MUL_W,
  localparam int unsigned OUT_W = REF_W + MFLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RATE_W-1:0] rate_kbps,
  input  logic [REF_W-1:0]  ref_khz,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [15:0]       cfg_word,
  output logic [OUT_W-1:0]  out_kbps,
  output logic              err
);
  calc_state_e state;

  logic [RATE_W-1:0] rate_q;
  logic [REF_W-1:0]  ref_q;
  logic [DIV_W-1:0]  div_q;
  logic [MUL_W-1:0]  mul_q;
  logic [1:0]        band_q;

  logic              srch_go, srch_done;
  logic [DIV_W-1:0]  srch_div;
  logic              dv_go, dv_done;
  logic [NUM_W-1:0]  dv_num, dv_quot;
  logic [REF_W-1:0]  dv_den;
  logic [1:0]        band_c;

  logic [NUM_W-1:0]  mul_num, out_num, dec_num;
  logic [MFLD_W-1:0] mfield;
  logic [DIV_W-1:0]  dfield;

  assign req_ready = (state == ST_IDLE);
  assign res_valid = (state == ST_HOLD);

  // multiplier field and divider field: zero decodes as one
  assign mfield = (mul_q[MFLD_W-1:0] == '0) ? MFLD_W'(1) : mul_q[MFLD_W-1:0];
  assign dfield = (div_q == '0) ? DIV_W'(1) : div_q;

  assign mul_num = NUM_W'(rate_q) * NUM_W'(srch_div) + NUM_W'(ref_q) - NUM_W'(1);
  assign out_num = NUM_W'(ref_q) * NUM_W'(dv_quot[MUL_W-1:0]);
  assign dec_num = NUM_W'(ref_q) * NUM_W'(mfield);

  pll_div_search #(.REF_W(REF_W)) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (srch_go),
    .ref_khz (ref_q),
    .done    (srch_done),
    .div     (srch_div)
  );

  pll_restoring_div #(.NW(NUM_W), .DW(REF_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (dv_go),
    .num  (dv_num),
    .den  (dv_den),
    .done (dv_done),
    .quot (dv_quot)
  );

  pll_band_enc #(.W(NUM_W)) u_band (
    .rate(dv_quot),
    .band(band_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rate_q   <= '0;
      ref_q    <= '0;
      div_q    <= DIV_W'(1);
      mul_q    <= '0;
      band_q   <= '0;
      srch_go  <= 1'b0;
      dv_go    <= 1'b0;
      dv_num   <= '0;
      dv_den   <= '0;
      cfg_word <= '0;
      out_kbps <= '0;
      err      <= 1'b0;
    end else begin
      srch_go <= 1'b0;
      dv_go   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            rate_q <= rate_kbps;
            ref_q  <= ref_khz;
            if (ref_khz == '0) begin
              cfg_word <= '0;
              out_kbps <= '0;
              err      <= 1'b1;
              state    <= ST_HOLD;
            end else begin
              srch_go <= 1'b1;
              state   <= ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (srch_done) begin
            div_q  <= srch_div;
            dv_num <= mul_num;
            dv_den <= ref_q;
            dv_go  <= 1'b1;
            state  <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (dv_done) begin
            mul_q  <= dv_quot[MUL_W-1:0];
            dv_num <= out_num;
            dv_den <= REF_W'(div_q);
            dv_go  <= 1'b1;
            state  <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (dv_done) begin
            band_q <= band_c;
            dv_num <= dec_num;
            dv_den <= REF_W'(dfield);
            dv_go  <= 1'b1;
            state  <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (dv_done) begin
            cfg_word <= {band_q, 1'b0, div_q, mul_q[MFLD_W-1:0]};
            out_kbps <= dv_quot[OUT_W-1:0];
            err      <= 1'b0;
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_word_calc_chk.sv
module pll_word_calc_chk #(
  parameter int unsigned OUT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [15:0]      cfg_word,
  input logic [OUT_W-1:0] out_kbps,
  input logic             err
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(cfg_word) && $stable(out_kbps) && $stable(err));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_layout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !err |-> (cfg_word[13] == 1'b0) && (cfg_word[12:8] != 5'd0));

  p_zero_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && err |-> (cfg_word == 16'd0) && (out_kbps == '0));
endmodule

bind pll_word_calc pll_word_calc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .cfg_word (cfg_word),
  .out_kbps (out_kbps),
  .err      (err)
);

// File: tb/pll_word_calc_test.sv
`timescale 1ns/1ps
module pll_word_calc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] rate_kbps = '0;
  logic [23:0] ref_khz = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [15:0] cfg_word;
  logic [31:0] out_kbps;
  logic        err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pll_word_calc uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rate_kbps(rate_kbps), .ref_khz(ref_khz), .res_valid(res_valid),
    .res_ready(res_ready), .cfg_word(cfg_word), .out_kbps(out_kbps), .err(err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent model of the requirements
  task automatic model(input longint rate, input longint rf,
                       output longint word, output longint freq);
    longint d, m, o, bnd, fld, mf;
    d = 1;
    while (rf / (d + 1) >= 5000) d++;
    if (d > 31) d = 31;
    m = (rate * d + rf - 1) / rf;
    o = rf * m / d;
    bnd = (o >= 501000) ? 3 : (o >= 251000) ? 2 : (o >= 126000) ? 1 : 0;
    fld = m & 255;
    mf  = (fld == 0) ? 1 : fld;
    word = (bnd << 14) | (d << 8) | fld;
    freq = rf * mf / d;
  endtask

  task automatic send(input longint rate, input longint rf);
    @(negedge clk);
    rate_kbps = 24'(rate);
    ref_khz   = 24'(rf);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_result(input string req);
    int n = 0;
    while (!res_valid && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({req, " result arrives"}, longint'(res_valid), 1);
  endtask

  task automatic pop(input string req);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check({req, " R9 valid drops after pop"}, longint'(res_valid), 0);
  endtask

  task automatic run_case(input string req, input longint rate, input longint rf);
    longint ew, ef;
    model(rate, rf, ew, ef);
    send(rate, rf);
    wait_result(req);
    check({req, " R5 word"}, longint'(cfg_word), ew);
    check({req, " R6 frequency"}, longint'(out_kbps), ef);
    check({req, " R7 err clear"}, longint'(err), 0);
    pop(req);
  endtask

  task automatic t_reset();
    check("R10 req_ready", longint'(req_ready), 1);
    check("R10 res_valid", longint'(res_valid), 0);
    check("R10 err", longint'(err), 0);
  endtask

  task automatic t_search();
    run_case("R1 div search 25000", 450000, 25000);
    run_case("R1 low ref keeps 1", 100000, 4000);
    run_case("R1 ref 10000 gives 2", 300000, 10000);
    check("R1 field of ref 10000", longint'(cfg_word[12:8]), 2);
  endtask

  task automatic t_clamp();
    run_case("R2 clamp", 900000, 200000);
    run_case("R2 clamp top ref", 1000000, 16000000);
  endtask

  task automatic t_ceil();
    run_case("R3 exact", 480000, 24000);
    run_case("R3 round up", 480001, 24000);
    run_case("R3 ref 27000", 333333, 27000);
  endtask

  task automatic t_bands();
    run_case("R4 at 501000", 501000, 1000);
    run_case("R4 below 501000", 500000, 1000);
    run_case("R4 at 251000", 251000, 1000);
    run_case("R4 at 250000", 250000, 1000);
    run_case("R4 at 126000", 126000, 1000);
    run_case("R4 at 125000", 125000, 1000);
    run_case("R4 wide multiplier", 2000000, 6000);
    check("R4 band from full rate", longint'(cfg_word[15:14]), 3);
  endtask

  task automatic t_zero_mul();
    run_case("R6 zero multiplier", 0, 30000);
  endtask

  task automatic t_zero_ref();
    send(123456, 0);
    wait_result("R7");
    check("R7 err set", longint'(err), 1);
    check("R7 word zero", longint'(cfg_word), 0);
    check("R7 freq zero", longint'(out_kbps), 0);
    pop("R7");
  endtask

  task automatic t_backpressure();
    longint ew, ef, ew2, ef2;
    model(450000, 25000, ew, ef);
    model(100000, 4000, ew2, ef2);
    send(450000, 25000);
    wait_result("R9");
    // next request waits at the edge while the result is unread
    rate_kbps = 24'(100000);
    ref_khz   = 24'(4000);
    req_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R9 valid held", longint'(res_valid), 1);
      check("R9 word held", longint'(cfg_word), ew);
      check("R9 freq held", longint'(out_kbps), ef);
      check("R8 ready low while pending", longint'(req_ready), 0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check("R8 idle after pop", longint'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 ready drops after accept", longint'(req_ready), 0);
    wait_result("R8");
    check("R8 queued word", longint'(cfg_word), ew2);
    check("R8 queued freq", longint'(out_kbps), ef2);
    pop("R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_search();
    t_clamp();
    t_ceil();
    t_bands();
    t_zero_mul();
    t_zero_ref();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule